// File: doc/BRIEF.md
# Dual polled interval timers

This block holds two programmable interval timers, A (10 bits) and B (8 bits). Software sets their periods and a shared control byte through byte-wide register writes. Each running timer counts up from its period value towards its all-ones maximum. On its own tick it then reloads and starts over. The expiry sets a sticky flag, and software polls that flag through a status byte. The block never raises an interrupt.

Timer A advances on every pulse of the base tick enable. Timer B advances on a slower tick that a parameterised divider derives from the same base tick. Timer A's period spans two registers, and software writes the high byte first. The low-byte write commits both halves at once, so a running timer never sees a half-updated period.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both flags are 0, `status` is 0x00, `mode` is 0, both timers are stopped and the base-tick divider is at zero.
- R2: A write to BASE_ADDR+0 only stages the high byte of timer A's period. A later write to BASE_ADDR+1 sets the period to {staged byte, data[1:0]}, and data[7:2] of that write is ignored. A high-byte write without a low-byte write leaves the period unchanged.
- R3: A write to BASE_ADDR+2 sets timer B's 8-bit period.
- R4: BASE_ADDR+3 is the control byte: bit0 load A, bit1 load B, bit2 enable A, bit3 enable B, bit4 clear A, bit5 clear B, bits[7:6] mode.
- R5: Writing load=1 to a stopped timer reloads its counter from the period and starts it. Writing load=1 to a timer that is already running has no effect. Writing load=0 stops the timer, and a stopped timer never expires.
- R6: A running timer of width W with period P expires on its (2^W − P)th tick. It then reloads P and repeats with the same interval.
- R7: A timer's enable bit decides only whether an expiry sets its flag. The counter runs the same way whatever the enable bit holds.
- R8: Timer B's tick occurs on every 16th base tick, counted from reset.
- R9: Flags are sticky. Writing 1 to a clear bit resets that flag only. The clear bit is not stored, so a later expiry sets the flag again.
- R10: If an enabled expiry and a clear of the same timer fall in the same cycle, the flag ends up set.
- R11: `status` bit0 is flag A, bit1 is flag B, and bits[7:2] read 0.
- R12: `mode` outputs control bits[7:6] from the last control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| flag_a | output | 1 | Sticky expiry flag of timer A |
| flag_b | output | 1 | Sticky expiry flag of timer B |
| status | output | 8 | Polled status byte |
| mode | output | 2 | Mode field of the control byte |

## Verification
An expiry of timer A and a software clear of its flag can happen in the same cycle. The bench provokes this by running timer A at period 1023, so that every tick expires it. It then drives a base tick during the very cycle of a control write that sets clear A and keeps load A set. The flag must still read 1 after that write, whereas the same clear with no tick must read 0. A stopped-timer write and a load to an already running timer are also exercised back to back with ticks, to show that neither disturbs the count.

// File: rtl/dit_pkg.sv
package dit_pkg;

  // Register offsets from the block base address.
  localparam logic [7:0] OFS_A_HI = 8'd0;
  localparam logic [7:0] OFS_A_LO = 8'd1;
  localparam logic [7:0] OFS_B    = 8'd2;
  localparam logic [7:0] OFS_CTRL = 8'd3;

  // Control byte layout, MSB first.
  typedef struct packed {
    logic [1:0] mode;
    logic       clr_b;
    logic       clr_a;
    logic       en_b;
    logic       en_a;
    logic       run_b;
    logic       run_a;
  } ctrl_t;

endpackage

// File: rtl/dit_regs.sv
module dit_regs
  import dit_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h24,
  parameter int         A_W       = 10,
  parameter int         B_W       = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_addr,
  input  logic [7:0]     wr_data,
  output logic [A_W-1:0] period_a,
  output logic [B_W-1:0] period_b,
  output logic           run_a,
  output logic           run_b,
  output logic           en_a,
  output logic           en_b,
  output logic           start_a,
  output logic           start_b,
  output logic           clr_a,
  output logic           clr_b,
  output logic [1:0]     mode
);

  localparam int         LO_W      = A_W - 8;
  localparam logic [7:0] ADDR_A_HI = BASE_ADDR + OFS_A_HI;
  localparam logic [7:0] ADDR_A_LO = BASE_ADDR + OFS_A_LO;
  localparam logic [7:0] ADDR_B    = BASE_ADDR + OFS_B;
  localparam logic [7:0] ADDR_CTRL = BASE_ADDR + OFS_CTRL;

  logic           sel_hi, sel_lo, sel_b, sel_ctrl;
  ctrl_t          wctrl;

  logic [7:0]     hi_q, hi_d;
  logic [A_W-1:0] pa_q, pa_d;
  logic [B_W-1:0] pb_q, pb_d;
  logic           run_a_q, run_a_d, run_b_q, run_b_d;
  logic           en_a_q, en_a_d, en_b_q, en_b_d;
  logic [1:0]     mode_q, mode_d;

  assign sel_hi   = wr_en && (wr_addr == ADDR_A_HI);
  assign sel_lo   = wr_en && (wr_addr == ADDR_A_LO);
  assign sel_b    = wr_en && (wr_addr == ADDR_B);
  assign sel_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wctrl    = ctrl_t'(wr_data);

  // Next-state logic
  always_comb begin
    hi_d    = hi_q;
    pa_d    = pa_q;
    pb_d    = pb_q;
    run_a_d = run_a_q;
    run_b_d = run_b_q;
    en_a_d  = en_a_q;
    en_b_d  = en_b_q;
    mode_d  = mode_q;
    if (sel_hi) begin
      hi_d = wr_data;
    end
    if (sel_lo) begin
      pa_d = {hi_q, wr_data[LO_W-1:0]};
    end
    if (sel_b) begin
      pb_d = wr_data[B_W-1:0];
    end
    if (sel_ctrl) begin
      run_a_d = wctrl.run_a;
      run_b_d = wctrl.run_b;
      en_a_d  = wctrl.en_a;
      en_b_d  = wctrl.en_b;
      mode_d  = wctrl.mode;
    end
  end

  // Pulses derived from the control write
  always_comb begin
    start_a = sel_ctrl && wctrl.run_a && !run_a_q;
    start_b = sel_ctrl && wctrl.run_b && !run_b_q;
    clr_a   = sel_ctrl && wctrl.clr_a;
    clr_b   = sel_ctrl && wctrl.clr_b;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      pa_q    <= '0;
      pb_q    <= '0;
      run_a_q <= 1'b0;
      run_b_q <= 1'b0;
      en_a_q  <= 1'b0;
      en_b_q  <= 1'b0;
      mode_q  <= '0;
    end else begin
      hi_q    <= hi_d;
      pa_q    <= pa_d;
      pb_q    <= pb_d;
      run_a_q <= run_a_d;
      run_b_q <= run_b_d;
      en_a_q  <= en_a_d;
      en_b_q  <= en_b_d;
      mode_q  <= mode_d;
    end
  end

  assign period_a = pa_q;
  assign period_b = pb_q;
  assign run_a    = run_a_q;
  assign run_b    = run_b_q;
  assign en_a     = en_a_q;
  assign en_b     = en_b_q;
  assign mode     = mode_q;

endmodule

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_out
);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_out = tick_in;
    end else begin : g_div
      localparam int          CW   = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          wrap;

      assign wrap = (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (tick_in) begin
          cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick_out = tick_in && wrap;
    end
  endgenerate

endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         start,
  input  logic [W-1:0] period,
  output logic         ovf
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_top;
  logic         step;

  assign at_top = (cnt_q == TOP);
  assign step   = run && tick && !start;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = period;
    end else if (step) begin
      cnt_d = at_top ? period : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign ovf = step && at_top;

endmodule

// File: rtl/dit_flag.sv
module dit_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  logic flag_q, flag_d;

  // An expiry in the same cycle as a clear keeps the flag set.
  always_comb begin
    flag_d = flag_q;
    if (set) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter logic [7:0] BASE_ADDR = 8'h24,
  parameter int         A_W       = 10,
  parameter int         B_W       = 8,
  parameter int         B_DIV     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       flag_a,
  output logic       flag_b,
  output logic [7:0] status,
  output logic [1:0] mode
);

  logic [A_W-1:0] period_a;
  logic [B_W-1:0] period_b;
  logic           run_a, run_b, en_a, en_b;
  logic           start_a, start_b, clr_a, clr_b;
  logic           b_tick;
  logic           ovf_a, ovf_b;

  dit_regs #(
    .BASE_ADDR (BASE_ADDR),
    .A_W       (A_W),
    .B_W       (B_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .period_a (period_a),
    .period_b (period_b),
    .run_a    (run_a),
    .run_b    (run_b),
    .en_a     (en_a),
    .en_b     (en_b),
    .start_a  (start_a),
    .start_b  (start_b),
    .clr_a    (clr_a),
    .clr_b    (clr_b),
    .mode     (mode)
  );

  dit_prescaler #(.DIV(B_DIV)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick),
    .tick_out (b_tick)
  );

  dit_counter #(.W(A_W)) u_cnt_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .run    (run_a),
    .start  (start_a),
    .period (period_a),
    .ovf    (ovf_a)
  );

  dit_counter #(.W(B_W)) u_cnt_b (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (b_tick),
    .run    (run_b),
    .start  (start_b),
    .period (period_b),
    .ovf    (ovf_b)
  );

  dit_flag u_flag_a (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ovf_a && en_a),
    .clr   (clr_a),
    .flag  (flag_a)
  );

  dit_flag u_flag_b (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ovf_b && en_b),
    .clr   (clr_b),
    .flag  (flag_b)
  );

  assign status = {6'b0, flag_b, flag_a};

endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
  parameter int B_DIV = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       b_tick,
  input logic       run_a,
  input logic       run_b,
  input logic       ovf_a,
  input logic       ovf_b,
  input logic       en_a,
  input logic       en_b,
  input logic       clr_a,
  input logic       clr_b,
  input logic       flag_a,
  input logic       flag_b,
  input logic [7:0] status
);

  localparam int CW = (B_DIV > 1) ? $clog2(B_DIV) : 1;

  // Independent count of base ticks since reset.
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (tick) begin
      seen_q <= (int'(seen_q) == B_DIV - 1) ? '0 : seen_q + 1'b1;
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |-> (status == 8'h00)); // R1

  AST_STOPPED_A_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_a |-> !ovf_a); // R5

  AST_STOPPED_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_b |-> !ovf_b); // R5

  AST_FLAG_A_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(ovf_a && en_a)); // R7

  AST_FLAG_B_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_b) |-> $past(ovf_b && en_b)); // R7

  AST_B_TICK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    b_tick |-> (tick && int'(seen_q) == B_DIV - 1)); // R8

  AST_FLAG_A_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_a) |-> $past(clr_a)); // R9

  AST_FLAG_B_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_b) |-> $past(clr_b)); // R9

  AST_COLLIDE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_a && en_a && clr_a) |=> flag_a); // R10

endmodule

bind dual_interval_timer dit_checker #(.B_DIV(B_DIV)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick   (tick),
  .b_tick (b_tick),
  .run_a  (run_a),
  .run_b  (run_b),
  .ovf_a  (ovf_a),
  .ovf_b  (ovf_b),
  .en_a   (en_a),
  .en_b   (en_b),
  .clr_a  (clr_a),
  .clr_b  (clr_b),
  .flag_a (flag_a),
  .flag_b (flag_b),
  .status (status)
);

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;

  localparam logic [7:0] BASE = 8'h24;
  localparam logic [7:0] A_HI = BASE + 8'd0;
  localparam logic [7:0] A_LO = BASE + 8'd1;
  localparam logic [7:0] B_PR = BASE + 8'd2;
  localparam logic [7:0] CTRL = BASE + 8'd3;

  // Vector: {hi[28:21], lo[20:13], ticks[12:1], expected flag A[0]}
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {8'hFF, 8'h03, 12'd1,  1'b1},
    {8'hFF, 8'h03, 12'd0,  1'b0},
    {8'hFF, 8'h00, 12'd3,  1'b0},
    {8'hFF, 8'h00, 12'd4,  1'b1},
    {8'hF0, 8'h02, 12'd61, 1'b0},
    {8'hF0, 8'h02, 12'd62, 1'b1},
    {8'hFE, 8'hFD, 12'd6,  1'b0},
    {8'hFE, 8'hFD, 12'd7,  1'b1}
  };

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       flag_a;
  logic       flag_b;
  logic [7:0] status;
  logic [1:0] mode;

  int  n_checks;
  int  n_fail;
  bit  done;

  dual_interval_timer u_dual_interval_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .flag_a  (flag_a),
    .flag_b  (flag_b),
    .status  (status),
    .mode    (mode)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    tick     = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    do_reset();

    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 flags", {6'b0, flag_b, flag_a}, 8'h00);
    check("R1 mode", {6'b0, mode}, 8'h00);

    // R6 R2 R4 table walk: period A and ticks to expiry
    for (int i = 0; i < NV; i++) begin
      wr(CTRL, 8'h10);               // stop A, clear A
      wr(A_HI, VEC[i][28:21]);
      wr(A_LO, VEC[i][20:13]);
      wr(CTRL, 8'h05);               // load A, enable A
      ticks(int'(VEC[i][12:1]));
      check($sformatf("R6 vector %0d flag A", i), {7'b0, flag_a}, {7'b0, VEC[i][0]});
    end

    // R2: high byte alone does not change the period (period stays 1023)
    wr(CTRL, 8'h10);
    wr(A_HI, 8'hFF);
    wr(A_LO, 8'h03);
    wr(A_HI, 8'h00);
    wr(CTRL, 8'h05);
    ticks(1);
    check("R2 staged high byte ignored", {7'b0, flag_a}, 8'h01);

    // R7: disabled expiry leaves flag clear, counter keeps running
    wr(CTRL, 8'h10);
    wr(CTRL, 8'h01);
    ticks(1);
    check("R7 disabled no flag", {7'b0, flag_a}, 8'h00);
    wr(CTRL, 8'h05);               // running already: only enable changes
    ticks(1);
    check("R7 enabled flag", {7'b0, flag_a}, 8'h01);

    // R5: load 0 stops timer
    wr(CTRL, 8'h14);
    ticks(5);
    check("R5 stopped no expiry", {7'b0, flag_a}, 8'h00);

    // R5: load 1 on running timer does not restart (period 1020)
    wr(A_HI, 8'hFF);
    wr(A_LO, 8'h00);
    wr(CTRL, 8'h05);
    ticks(2);
    wr(CTRL, 8'h05);
    ticks(2);
    check("R5 rewrite load no restart", {7'b0, flag_a}, 8'h01);

    // R9 R6: clear while running, then periodic re-expiry (period 1022)
    wr(CTRL, 8'h10);
    wr(A_LO, 8'h02);
    wr(CTRL, 8'h05);
    ticks(2);
    check("R6 first expiry", {7'b0, flag_a}, 8'h01);
    wr(CTRL, 8'h15);
    check("R9 clear", {7'b0, flag_a}, 8'h00);
    ticks(1);
    check("R6 mid interval", {7'b0, flag_a}, 8'h00);
    ticks(1);
    check("R9 clear not stored, re-expiry", {7'b0, flag_a}, 8'h01);

    // R10: expiry and clear in the same cycle (period 1023)
    wr(CTRL, 8'h10);
    wr(A_LO, 8'h03);
    wr(CTRL, 8'h05);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = CTRL;
    wr_data = 8'h15;
    tick    = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    tick    = 1'b0;
    check("R10 collision keeps flag", {7'b0, flag_a}, 8'h01);

    // R8 R3: timer B period 250 expires on base tick 96
    do_reset();
    wr(B_PR, 8'd250);
    wr(CTRL, 8'h0A);
    ticks(95);
    check("R8 B before expiry", {7'b0, flag_b}, 8'h00);
    ticks(1);
    check("R3 B expiry", {7'b0, flag_b}, 8'h01);
    check("R11 status B only", status, 8'h02);

    // R11: both flags
    wr(A_HI, 8'hFF);
    wr(A_LO, 8'h03);
    wr(CTRL, 8'h0F);
    ticks(1);
    check("R11 status both", status, 8'h03);
    check("R12 mode zero", {6'b0, mode}, 8'h00);

    // R9: clear B only
    wr(CTRL, 8'h2F);
    check("R9 clear B only", status, 8'h01);

    // R12 R4: mode field
    wr(CTRL, 8'hC0);
    check("R12 mode field", {6'b0, mode}, 8'h03);
    ticks(3);
    check("R4 load bits zero stop both", status, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule